// File: doc/BRIEF.md
# Read-to-Lock Hardware Semaphore

This block is a one-bit hardware lock that lets several independent processors share one peripheral. Each processor reaches it through its own simple register port (read strobe, write strobe, byte address, byte write data, byte read data). The lock lives in bit 0 of a byte-wide status register at offset 0x08. Reading that register is an atomic test-and-set. If the lock was free, the read returns 0 and the reader becomes the owner. If the lock was already held, the read returns 1 and nothing changes. The owner releases the lock by writing a byte with bit 0 set to the same register.

The block drives the lock state and the owning port number as outputs, so the peripheral's other registers can be gated to the current owner. Reads that arrive in the same cycle are settled by fixed priority: the lowest-numbered port wins. A release write from any port that does not own the lock is ignored and raises a sticky error flag, which only reset clears. Read data is registered and appears on the port's read-data bus one clock after the read strobe. It holds its value until that port reads again.

Top module: `hw_semaphore`

## Requirements
- R1: After reset the lock is free, `owner_id` is 0, `err_flag` is 0 and every read-data bus is 0.
- R2: A status read (address 0x08) while the lock is free returns 0x00 on that port one cycle later. In the same edge the lock becomes taken and `owner_id` becomes that port's index.
- R3: A status read while the lock is taken returns 0x01, the owner included. Lock state and `owner_id` stay unchanged.
- R4: When several ports read the status register in the same cycle while the lock is free, the lowest-indexed one receives 0x00 and becomes owner. All the others receive 0x01.
- R5: A write from the owning port to address 0x08 with bit 0 = 1 frees the lock on the next edge and returns `owner_id` to 0.
- R6: A write to address 0x08 with bit 0 = 0 has no effect on lock, owner or error flag, whatever the upper bits are.
- R7: A write to address 0x08 with bit 0 = 1 from a port that is not the owner, or while the lock is free, changes neither lock nor owner and sets `err_flag`. `err_flag` stays 1 until reset.
- R8: Accesses to any address other than 0x08 leave lock, owner and error flag unchanged. Such reads return 0x00.
- R9: A read and an owner release in the same cycle: the read sees the state before the release (0x01) and does not claim the lock, and the lock ends up free.
- R10: Bits 7..1 of every status read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | N_PORTS | Per-port read strobe |
| wr_en | input | N_PORTS | Per-port write strobe |
| addr | input | N_PORTS*ADDR_W | Per-port byte address, port i in slice i |
| wdata | input | N_PORTS*DATA_W | Per-port write data |
| rdata | output | N_PORTS*DATA_W | Per-port registered read data |
| lock_taken | output | 1 | Lock currently held |
| owner_id | output | ID_W | Index of the owning port (0 when free) |
| err_flag | output | 1 | Sticky: a release attempt by a non-owner was seen |

## Verification
The hardest situations to reach are the same-cycle collisions: two or more ports claiming a free lock at once, and a claim that lands in the very cycle the owner releases. Random per-port strobes that mostly target the status address make both happen often. Directed steps also force each one on purpose, including a low-priority port racing a higher one and a release overlapping a read.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;
  // decoded per-port request for one cycle
  typedef struct packed {
    logic claim;   // status read
    logic free1;   // status write with bit0 set
  } port_req_t;

  function automatic int unsigned id_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import hwsem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOCK_OFS = 8
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_req_t         req
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(LOCK_OFS);

  logic hit;
  assign hit = (addr == OFS);

  always_comb begin
    req.claim = rd_en & hit;
    req.free1 = wr_en & hit & wdata[0];
  end
endmodule

// File: rtl/sem_prio_arb.sv
module sem_prio_arb #(
  parameter int unsigned N    = 4,
  parameter int unsigned ID_W = 2
) (
  input  logic [N-1:0]    req,
  output logic [N-1:0]    gnt,
  output logic [ID_W-1:0] gnt_idx,
  output logic            any
);
  // lower index wins
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]       = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];

  always_comb begin
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = ID_W'(i);
    end
  end
endmodule

// File: rtl/sem_lock_core.sv
module sem_lock_core #(
  parameter int unsigned N    = 4,
  parameter int unsigned ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    free1,
  input  logic            claim_any,
  input  logic [ID_W-1:0] claim_idx,
  output logic            lock_q,
  output logic [ID_W-1:0] owner_q,
  output logic            err_q
);
  logic [N-1:0] owner_mask;
  logic         release_ok;
  logic         bad_free;

  always_comb begin
    owner_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (lock_q && owner_q == ID_W'(i)) owner_mask[i] = 1'b1;
    end
  end

  assign release_ok = |(free1 & owner_mask);
  assign bad_free   = |(free1 & ~owner_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (bad_free) err_q <= 1'b1;
      if (release_ok) begin
        lock_q  <= 1'b0;
        owner_q <= '0;
      end else if (!lock_q && claim_any) begin
        lock_q  <= 1'b1;
        owner_q <= claim_idx;
      end
    end
  end
endmodule

// File: rtl/hw_semaphore.sv
module hw_semaphore
  import hwsem_pkg::*;
#(
  parameter int unsigned N_PORTS  = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOCK_OFS = 8,
  localparam int unsigned ID_W    = id_width(N_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PORTS-1:0]          rd_en,
  input  logic [N_PORTS-1:0]          wr_en,
  input  logic [N_PORTS*ADDR_W-1:0]   addr,
  input  logic [N_PORTS*DATA_W-1:0]   wdata,
  output logic [N_PORTS*DATA_W-1:0]   rdata,
  output logic                        lock_taken,
  output logic [ID_W-1:0]             owner_id,
  output logic                        err_flag
);
  port_req_t [N_PORTS-1:0] req;
  logic [N_PORTS-1:0] claim_v, free1_v, gnt;
  logic [ID_W-1:0]    gnt_idx;
  logic               claim_any;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    sem_port_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_OFS(LOCK_OFS)
    ) u_dec (
      .rd_en (rd_en[i]),
      .wr_en (wr_en[i]),
      .addr  (addr[i*ADDR_W +: ADDR_W]),
      .wdata (wdata[i*DATA_W +: DATA_W]),
      .req   (req[i])
    );
    assign claim_v[i] = req[i].claim;
    assign free1_v[i] = req[i].free1;

    // registered read data: state before this edge decides the answer
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[i*DATA_W +: DATA_W] <= '0;
      end else if (rd_en[i]) begin
        if (claim_v[i])
          rdata[i*DATA_W +: DATA_W] <= {{(DATA_W-1){1'b0}}, lock_taken | ~gnt[i]};
        else
          rdata[i*DATA_W +: DATA_W] <= '0;
      end
    end
  end

  sem_prio_arb #(.N(N_PORTS), .ID_W(ID_W)) u_arb (
    .req     (claim_v),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (claim_any)
  );

  sem_lock_core #(.N(N_PORTS), .ID_W(ID_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .free1     (free1_v),
    .claim_any (claim_any),
    .claim_idx (gnt_idx),
    .lock_q    (lock_taken),
    .owner_q   (owner_id),
    .err_q     (err_flag)
  );
endmodule

// File: rtl/sem_chk.sv
module sem_chk #(
  parameter int unsigned N_PORTS  = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOCK_OFS = 8,
  parameter int unsigned ID_W     = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_PORTS-1:0]        rd_en,
  input logic [N_PORTS-1:0]        wr_en,
  input logic [N_PORTS*ADDR_W-1:0] addr,
  input logic [N_PORTS*DATA_W-1:0] wdata,
  input logic [N_PORTS*DATA_W-1:0] rdata,
  input logic                      lock_taken,
  input logic [ID_W-1:0]           owner_id,
  input logic                      err_flag
);
  logic [N_PORTS-1:0] st_rd, st_rd_q, busy_rd_q, rbit0;
  logic               own_rel;

  always_comb begin
    own_rel = 1'b0;
    for (int i = 0; i < N_PORTS; i++) begin
      st_rd[i] = rd_en[i] && (addr[i*ADDR_W +: ADDR_W] == ADDR_W'(LOCK_OFS));
      rbit0[i] = rdata[i*DATA_W];
      if (wr_en[i] && owner_id == ID_W'(i) &&
          addr[i*ADDR_W +: ADDR_W] == ADDR_W'(LOCK_OFS) && wdata[i*DATA_W])
        own_rel = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_rd_q   <= '0;
      busy_rd_q <= '0;
    end else begin
      st_rd_q   <= st_rd;
      busy_rd_q <= st_rd & {N_PORTS{lock_taken}};
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!lock_taken && !err_flag));
  // R2
  acquire_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_taken && |st_rd) |=> lock_taken);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_taken && !own_rel) |=> (lock_taken && $stable(owner_id)));
  // R3
  busy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_rd_q & ~rbit0) == '0);
  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(st_rd_q & ~rbit0) <= 1);
  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_taken && own_rel) |=> !lock_taken);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind hw_semaphore sem_chk #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .LOCK_OFS(LOCK_OFS), .ID_W(ID_W)
) u_sem_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .lock_taken(lock_taken),
  .owner_id(owner_id), .err_flag(err_flag)
);

// File: tb/tb_hw_semaphore.sv
module tb_hw_semaphore;
  localparam int N   = 4;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int OFS = 8;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    rd_en = '0, wr_en = '0;
  logic [N*AW-1:0] addr  = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N*DW-1:0] rdata;
  logic            lock_taken, err_flag;
  logic [IW-1:0]   owner_id;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit      m_busy, m_err;
  int      m_owner;
  int      m_rd [N];

  always #10 clk = ~clk;

  hw_semaphore #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .LOCK_OFS(OFS)) dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lock_taken(lock_taken),
    .owner_id(owner_id), .err_flag(err_flag)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lowest_claim(input bit cl [N]);
    for (int i = 0; i < N; i++) if (cl[i]) return i;
    return -1;
  endfunction

  // update the reference with the inputs currently driven
  task automatic model_step();
    bit cl [N];
    bit f1 [N];
    int win;
    bit rel;
    for (int i = 0; i < N; i++) begin
      cl[i] = rd_en[i] && addr[i*AW +: AW] == AW'(OFS);
      f1[i] = wr_en[i] && addr[i*AW +: AW] == AW'(OFS) && wdata[i*DW];
    end
    win = lowest_claim(cl);
    for (int i = 0; i < N; i++) begin
      if (rd_en[i]) m_rd[i] = cl[i] ? ((m_busy || win != i) ? 1 : 0) : 0;
      if (f1[i] && !(m_busy && m_owner == i)) m_err = 1;
    end
    rel = m_busy && f1[m_owner];
    if (rel) begin
      m_busy = 0; m_owner = 0;
    end else if (!m_busy && win >= 0) begin
      m_busy = 1; m_owner = win;
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " lock"}, int'(lock_taken), int'(m_busy));
    chk({tag, " owner"}, int'(owner_id), m_owner);
    chk({tag, " err"}, int'(err_flag), int'(m_err));
    for (int i = 0; i < N; i++)
      chk({tag, " rdata"}, int'(rdata[i*DW +: DW]), m_rd[i]);
    rd_en = '0; wr_en = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; rd_en = '0; wr_en = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_busy = 0; m_err = 0; m_owner = 0;
    for (int i = 0; i < N; i++) m_rd[i] = 0;
  endtask

  task automatic rd(int p, int a);
    rd_en[p] = 1'b1; addr[p*AW +: AW] = AW'(a);
  endtask

  task automatic wr(int p, int a, int d);
    wr_en[p] = 1'b1; addr[p*AW +: AW] = AW'(a); wdata[p*DW +: DW] = DW'(d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // R1 reset state
    chk("R1 lock", int'(lock_taken), 0);
    chk("R1 owner", int'(owner_id), 0);
    chk("R1 err", int'(err_flag), 0);
    chk("R1 rdata", int'(rdata == '0), 1);

    rd(2, OFS);               step("R2 claim by port 2");
    chk("R2 rdata2", int'(rdata[2*DW +: DW]), 0);
    rd(0, OFS);               step("R3 busy read");
    chk("R10 rdata0 byte", int'(rdata[0 +: DW]), 1);
    rd(2, OFS);               step("R3 owner rereads");
    wr(2, OFS, 8'hFE);        step("R6 write bit0 zero");
    chk("R6 still held", int'(lock_taken), 1);
    wr(0, OFS, 8'h01);        step("R7 non-owner release");
    chk("R7 err set", int'(err_flag), 1);
    chk("R7 owner kept", int'(owner_id), 2);
    wr(2, OFS, 8'h01); rd(1, OFS); step("R9 release with read");
    chk("R9 read sees held", int'(rdata[1*DW +: DW]), 1);
    chk("R5 freed", int'(lock_taken), 0);
    rd(3, OFS); rd(1, OFS);   step("R4 collision");
    chk("R4 winner", int'(rdata[1*DW +: DW]), 0);
    chk("R4 loser", int'(rdata[3*DW +: DW]), 1);
    wr(1, OFS, 8'h03);        step("R5 owner release");
    rd(3, 4);                 step("R8 other offset read");
    chk("R8 not claimed", int'(lock_taken), 0);
    wr(3, 4, 8'hFF);          step("R8 other offset write");
    wr(0, OFS, 8'h01);        step("R7 release while free");
    chk("R7 sticky", int'(err_flag), 1);

    do_reset();
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < N; p++) begin
        int a;
        a = ($urandom % 5 == 0) ? int'($urandom % 16) : OFS;
        if ($urandom % 10 < 3) rd(p, a);
        else if ($urandom % 10 < 2) wr(p, a, int'($urandom % 256));
      end
      step("random R2/R3/R4/R5/R7");
    end
    finish_run();
  end
endmodule